// File: doc/BRIEF.md
# Multi-Width Serial Lane Shifter

This block is the bit-level front end of a serial memory slave. It sits between the serial pins and the byte-level command engine. Inbound, it packs bits sampled on serial clock rising edges into bytes. Outbound, it breaks read bytes into bits that change on serial clock falling edges. It also drives the output enables of the data lanes. Both serial clock edges arrive as single-cycle strobes in the system clock domain, and all logic runs on that clock.

The bus can be one lane wide (input on lane 0, output on lane 1), two lanes wide (lanes 0 and 1 bidirectional) or four lanes wide (lanes 0 to 3 bidirectional). The width is changed in-band. The first byte of a selection can be an enter-dual opcode (0x3B), an enter-quad opcode (0x38) or a back-to-single opcode (0xFF), each sent at the current width. The new width applies from the next selection onward.

The command engine signals the start of read data with a one-cycle `read_go`. In the wide modes the shifter first spends one byte's worth of clocks on a turnaround dummy byte, then streams bytes taken from `tx_byte`.

Top module: `lane_shifter`

## Requirements
- R1: After reset the bus width is single lane (`bus_mode` = 0), all lane enables are 0 and `rx_valid` is 0.
- R2: In single-lane mode, each rising strobe while selected shifts `lane_in[0]` in, MSB first. One system clock after the eighth rising strobe, `rx_valid` pulses for one cycle with the byte on `rx_byte`.
- R3: In dual mode each rising strobe takes two bits, with the higher bit on lane 1 and the lower on lane 0. In quad mode each rising strobe takes a nibble from `lane_in[3:0]`, high nibble first. A byte therefore completes after 4 or 2 strobes.
- R4: A first byte of 0x3B or 0x38 in a selection sets `bus_mode` to 1 (dual) or 2 (quad). `bus_mode` does not change while the chip stays selected, and it changes one clock after `cs_n` goes high.
- R5: A first byte of 0xFF, sent at the current width (4 clocks in dual, 2 clocks in quad), returns `bus_mode` to 0.
- R6: Mode opcodes in any byte other than the first of a selection leave `bus_mode` unchanged.
- R7: In single-lane mode, read bits appear MSB first on `lane_out[1]`, starting at the first falling strobe after `read_go`. `lane_oe` is 4'b0010 only while read bits are being driven, and 0 before that.
- R8: In dual and quad mode, `read_go` is followed by 4 or 2 falling strobes of dummy output (lanes 0, enables 4'b0011 or 4'b1111). After that, data is driven: dual puts the higher bit on lane 1; quad puts the high nibble first on lanes 3..0.
- R9: One clock after `cs_n` goes high, all lane enables are 0 and any partly received byte is discarded.
- R10: `tx_take` pulses for one cycle at the falling strobe that starts each read byte. `tx_byte` is loaded then, so consecutive bytes stream without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck_rise | input | 1 | One-cycle strobe: serial clock rising edge |
| sck_fall | input | 1 | One-cycle strobe: serial clock falling edge |
| lane_in | input | 4 | Sampled levels of data lanes 3..0 |
| lane_out | output | 4 | Output levels for data lanes 3..0 |
| lane_oe | output | 4 | Output enables for data lanes 3..0 |
| rx_byte | output | 8 | Last assembled inbound byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` is new |
| read_go | input | 1 | Command engine: start the read phase |
| tx_byte | input | 8 | Next outbound read byte |
| tx_take | output | 1 | One-cycle pulse: `tx_byte` was loaded |
| bus_mode | output | 2 | Current width: 0 single, 1 dual, 2 quad |

## Verification
`rx_valid` is due one system clock after the rising strobe that completes a byte. `lane_out`, `lane_oe` and `tx_take` update in the clock that registers a falling strobe. `bus_mode` follows one clock after deselection. The bench drives each strobe for one cycle from the falling clock edge. It reads lane outputs and `tx_take` at the next falling clock edge after the strobe ends, which is one registered stage later. A scoreboard monitor compares every `rx_valid` pulse at falling clock edges against the queue of bytes the driver has sent. Mode checks wait two clocks after `cs_n` rises.

// File: rtl/lane_shift_pkg.sv
`timescale 1ns/1ps
package lane_shift_pkg;

    localparam int BYTE_W = 8;
    localparam int LANE_N = 4;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_ENTER_X2  = 8'h3B;
    localparam logic [BYTE_W-1:0] OP_ENTER_X4  = 8'h38;
    localparam logic [BYTE_W-1:0] OP_EXIT_WIDE = 8'hFF;

    typedef enum logic [1:0] {
        BUS_X1 = 2'd0,
        BUS_X2 = 2'd1,
        BUS_X4 = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_TURN = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // bits moved per serial clock
    function automatic logic [CNT_W-1:0] step_bits(bus_mode_e m);
        case (m)
            BUS_X1:  return CNT_W'(1);
            BUS_X2:  return CNT_W'(2);
            default: return CNT_W'(4);
        endcase
    endfunction

    // lanes owned by the slave while it drives
    function automatic logic [LANE_N-1:0] drive_mask(bus_mode_e m);
        case (m)
            BUS_X1:  return 4'b0010;
            BUS_X2:  return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // leading bits of a byte placed onto the lanes
    function automatic logic [LANE_N-1:0] head_lanes(bus_mode_e m, logic [BYTE_W-1:0] b);
        case (m)
            BUS_X1:  return {2'b00, b[7], 1'b0};
            BUS_X2:  return {2'b00, b[7:6]};
            default: return b[7:4];
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] shift_out(bus_mode_e m, logic [BYTE_W-1:0] b);
        case (m)
            BUS_X1:  return {b[6:0], 1'b0};
            BUS_X2:  return {b[5:0], 2'b00};
            default: return {b[3:0], 4'b0000};
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(bus_mode_e m, logic [BYTE_W-1:0] sh,
                                                   logic [LANE_N-1:0] l);
        case (m)
            BUS_X1:  return {sh[6:0], l[0]};
            BUS_X2:  return {sh[5:0], l[1:0]};
            default: return {sh[3:0], l};
        endcase
    endfunction

endpackage

// File: rtl/lane_deser.sv
`timescale 1ns/1ps
module lane_deser
    import lane_shift_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sck_rise,
    input  logic                enable,
    input  bus_mode_e           mode,
    input  logic [LANE_N-1:0]   lane_in,
    output logic [BYTE_W-1:0]   rx_byte,
    output logic                rx_valid
);

    logic [BYTE_W-1:0] sh_q, sh_nxt;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;

    always_comb begin
        sh_nxt  = shift_in(mode, sh_q, lane_in);
        cnt_nxt = cnt_q + step_bits(mode);
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            rx_valid <= 1'b0;
            if (rst) rx_byte <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sck_rise && enable) begin
                if (cnt_nxt == BYTE_CNT) begin
                    cnt_q    <= '0;
                    sh_q     <= '0;
                    rx_byte  <= sh_nxt;
                    rx_valid <= 1'b1;
                end else begin
                    cnt_q <= cnt_nxt;
                    sh_q  <= sh_nxt;
                end
            end
        end
    end

    // R2: completion is a single-cycle pulse
    a_r2_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9: deselection drops any byte in progress
    a_r9_no_valid_after_deselect: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !rx_valid);

endmodule

// File: rtl/bus_mode_ctl.sv
`timescale 1ns/1ps
module bus_mode_ctl
    import lane_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output bus_mode_e         mode
);

    bus_mode_e pend_q;
    logic      first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= BUS_X1;
            pend_q  <= BUS_X1;
            first_q <= 1'b1;
        end else if (cs_n) begin
            first_q <= 1'b1;
            mode    <= pend_q;
        end else if (rx_valid) begin
            first_q <= 1'b0;
            if (first_q) begin
                case (rx_byte)
                    OP_ENTER_X2:  pend_q <= BUS_X2;
                    OP_ENTER_X4:  pend_q <= BUS_X4;
                    OP_EXIT_WIDE: pend_q <= BUS_X1;
                    default:      pend_q <= pend_q;
                endcase
            end
        end
    end

    // R4: width only moves across a deselected cycle
    a_r4_mode_held_while_selected: assert property (@(posedge clk) disable iff (rst)
        !$past(cs_n) |-> $stable(mode));

    // R4: only the three defined widths ever appear
    a_r4_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode != bus_mode_e'(2'd3));

endmodule

// File: rtl/lane_ser.sv
`timescale 1ns/1ps
module lane_ser
    import lane_shift_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sck_fall,
    input  logic                read_go,
    input  bus_mode_e           mode,
    input  logic [BYTE_W-1:0]   tx_byte,
    output logic                tx_take,
    output logic                in_read,
    output logic [LANE_N-1:0]   lane_out,
    output logic [LANE_N-1:0]   lane_oe
);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic [BYTE_W-1:0] sh_q;
    logic              drive_q;

    always_comb begin
        cnt_nxt = cnt_q + step_bits(mode);
        in_read = (phase_q != PH_CMD);
        lane_oe = drive_q ? drive_mask(mode) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            phase_q  <= PH_CMD;
            cnt_q    <= '0;
            sh_q     <= '0;
            drive_q  <= 1'b0;
            lane_out <= '0;
            tx_take  <= 1'b0;
        end else begin
            tx_take <= 1'b0;
            if (phase_q == PH_CMD) begin
                if (read_go) begin
                    phase_q <= (mode == BUS_X1) ? PH_DATA : PH_TURN;
                    cnt_q   <= '0;
                end
            end else if (sck_fall) begin
                drive_q <= 1'b1;
                if (phase_q == PH_TURN) begin
                    lane_out <= '0;
                    if (cnt_nxt == BYTE_CNT) begin
                        phase_q <= PH_DATA;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_nxt;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        lane_out <= head_lanes(mode, tx_byte);
                        sh_q     <= shift_out(mode, tx_byte);
                        tx_take  <= 1'b1;
                    end else begin
                        lane_out <= head_lanes(mode, sh_q);
                        sh_q     <= shift_out(mode, sh_q);
                    end
                    cnt_q <= (cnt_nxt == BYTE_CNT) ? '0 : cnt_nxt;
                end
            end
        end
    end

    // R9: enables drop one clock after deselection
    a_r9_oe_off_after_deselect: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (lane_oe == '0));

    // R8: lanes are driven only inside a read
    a_r8_oe_only_in_read: assert property (@(posedge clk) disable iff (rst)
        (lane_oe != '0) |-> in_read);

    // R10: a byte is taken only on a falling strobe
    a_r10_take_on_fall: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> $past(sck_fall));

    // R7: single-lane reads never drive lanes 0, 2 or 3
    a_r7_single_lane_only: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_X1) |-> ((lane_oe & 4'b1101) == '0));

endmodule

// File: rtl/lane_shifter.sv
`timescale 1ns/1ps
module lane_shifter
    import lane_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [3:0]        lane_in,
    output logic [3:0]        lane_out,
    output logic [3:0]        lane_oe,
    output logic [7:0]        rx_byte,
    output logic              rx_valid,
    input  logic              read_go,
    input  logic [7:0]        tx_byte,
    output logic              tx_take,
    output logic [1:0]        bus_mode
);

    bus_mode_e mode;
    logic      in_read;

    lane_deser u_deser (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .enable   (!in_read),
        .mode     (mode),
        .lane_in  (lane_in),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    bus_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .mode     (mode)
    );

    lane_ser u_ser (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sck_fall (sck_fall),
        .read_go  (read_go),
        .mode     (mode),
        .tx_byte  (tx_byte),
        .tx_take  (tx_take),
        .in_read  (in_read),
        .lane_out (lane_out),
        .lane_oe  (lane_oe)
    );

    assign bus_mode = mode;

    // R1: reset leaves the bus single-lane and undriven
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (bus_mode == 2'd0 && lane_oe == 4'b0 && !rx_valid));

endmodule

// File: tb/lane_shifter_bench.sv
`timescale 1ns/1ps
module lane_shifter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck_rise = 1'b0;
    logic       sck_fall = 1'b0;
    logic [3:0] lane_in = 4'h0;
    logic [3:0] lane_out, lane_oe;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       read_go = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_take;
    logic [1:0] bus_mode;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    lane_shifter u_lane_shifter (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .lane_in(lane_in), .lane_out(lane_out), .lane_oe(lane_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .read_go(read_go),
        .tx_byte(tx_byte), .tx_take(tx_take), .bus_mode(bus_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor for inbound bytes
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected rx byte", rx_byte, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rx_byte == e, t, "rx byte", rx_byte, e);
            end
        end
    end

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic clk_bits(input logic [3:0] v, output logic [3:0] o,
                            output logic [3:0] oe, output logic tk);
        @(negedge clk) begin lane_in = v; sck_rise = 1'b1; end
        @(negedge clk) sck_rise = 1'b0;
        @(negedge clk) sck_fall = 1'b1;
        @(negedge clk) sck_fall = 1'b0;
        o = lane_out; oe = lane_oe; tk = tx_take;
    endtask

    task automatic send_byte(input logic [7:0] b, input int w, input string tag,
                             input bit expect_rx);
        logic [7:0] s;
        logic [3:0] v, o, oe;
        logic tk;
        s = b;
        if (expect_rx) begin
            exp_q.push_back(b);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < 8 / w; i++) begin
            case (w)
                1:       v = {3'b000, s[7]};
                2:       v = {2'b00, s[7:6]};
                default: v = s[7:4];
            endcase
            s = s << w;
            clk_bits(v, o, oe, tk);
        end
    endtask

    function automatic logic [3:0] mask_of(input int w);
        return (w == 1) ? 4'b0010 : (w == 2) ? 4'b0011 : 4'b1111;
    endfunction

    task automatic read_check(input int w, input logic [7:0] b0, input logic [7:0] b1);
        logic [7:0] s;
        logic [3:0] o, oe, ex;
        logic tk;
        int takes;
        string rq;
        rq = (w == 1) ? "R7" : "R8";
        tx_byte = b0;
        chk(lane_oe == 4'b0, rq, "oe before read", lane_oe, 0);
        @(negedge clk) read_go = 1'b1;
        @(negedge clk) read_go = 1'b0;
        if (w != 1) begin
            for (int i = 0; i < 8 / w; i++) begin
                clk_bits(4'h0, o, oe, tk);
                chk(o == 4'h0, "R8", "dummy lanes", o, 0);
                chk(oe == mask_of(w), "R8", "dummy oe", oe, mask_of(w));
                chk(tk == 1'b0, "R8", "no take in dummy", tk, 0);
            end
        end
        takes = 0;
        s = b0;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 8 / w; i++) begin
                clk_bits(4'h0, o, oe, tk);
                if (tk) begin
                    takes++;
                    tx_byte = b1;
                end
                case (w)
                    1:       ex = {2'b00, s[7], 1'b0};
                    2:       ex = {2'b00, s[7:6]};
                    default: ex = s[7:4];
                endcase
                s = s << w;
                chk(o == ex, rq, "read lanes", o, ex);
                chk(oe == mask_of(w), rq, "read oe", oe, mask_of(w));
                chk(tk == (i == 0), "R10", "take timing", tk, (i == 0));
            end
            s = b1;
        end
        chk(takes == 2, "R10", "takes per two bytes", takes, 2);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WDOG", "run did not finish", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] o, oe;
        logic tk;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(bus_mode == 2'd0, "R1", "mode after reset", bus_mode, 0);
        chk(lane_oe == 4'b0, "R1", "oe after reset", lane_oe, 0);
        chk(rx_valid == 1'b0, "R1", "valid after reset", rx_valid, 0);

        // R2 single-lane bytes; R6 opcode not first
        sel();
        send_byte(8'hA5, 1, "R2", 1);
        send_byte(8'h3B, 1, "R2", 1);
        send_byte(8'h38, 1, "R2", 1);
        desel();
        chk(bus_mode == 2'd0, "R6", "late opcode ignored", bus_mode, 0);

        // R4 enter dual
        sel();
        send_byte(8'h3B, 1, "R2", 1);
        chk(bus_mode == 2'd0, "R4", "mode held while selected", bus_mode, 0);
        desel();
        chk(bus_mode == 2'd1, "R4", "dual after deselect", bus_mode, 1);

        // R3 dual bytes
        sel();
        send_byte(8'h5A, 2, "R3", 1);
        send_byte(8'hC3, 2, "R3", 1);
        desel();
        chk(bus_mode == 2'd1, "R6", "non-opcode keeps dual", bus_mode, 1);

        // R8 / R10 dual read
        sel();
        send_byte(8'h03, 2, "R3", 1);
        read_check(2, 8'h9C, 8'h47);
        desel();
        chk(lane_oe == 4'b0, "R9", "oe off after deselect", lane_oe, 0);

        // R9 partial byte discarded
        sel();
        clk_bits(4'h3, o, oe, tk);
        clk_bits(4'h1, o, oe, tk);
        desel();
        sel();
        send_byte(8'h66, 2, "R9", 1);
        desel();

        // R4 enter quad from dual
        sel();
        send_byte(8'h38, 2, "R3", 1);
        desel();
        chk(bus_mode == 2'd2, "R4", "quad after deselect", bus_mode, 2);

        // R3 quad byte, R8 quad read
        sel();
        send_byte(8'hE1, 4, "R3", 1);
        desel();
        sel();
        send_byte(8'h0B, 4, "R3", 1);
        read_check(4, 8'hB4, 8'h2D);
        desel();
        chk(lane_oe == 4'b0, "R9", "oe off after quad read", lane_oe, 0);

        // R5 exit from quad
        sel();
        send_byte(8'hFF, 4, "R5", 1);
        desel();
        chk(bus_mode == 2'd0, "R5", "single after quad exit", bus_mode, 0);

        // R5 exit from dual
        sel();
        send_byte(8'h3B, 1, "R4", 1);
        desel();
        chk(bus_mode == 2'd1, "R4", "dual again", bus_mode, 1);
        sel();
        send_byte(8'hFF, 2, "R5", 1);
        desel();
        chk(bus_mode == 2'd0, "R5", "single after dual exit", bus_mode, 0);

        // R7 single-lane read
        sel();
        send_byte(8'h03, 1, "R2", 1);
        read_check(1, 8'hD2, 8'h6B);
        desel();
        chk(lane_oe == 4'b0, "R9", "oe off after single read", lane_oe, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "all sent bytes seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule